// File: doc/BRIEF.md
# Extended-Condition Block Sequencer

This block moves rarely used flag conditions out of every instruction word and into a single setup instruction. The setup instruction supplies a 4-bit extended condition code, the current carry (C) and zero (Z) flags and a block length. The sequencer evaluates the condition once and latches the result. It then governs the next `len_i` issued instructions. Each of those instructions executes only when the latched result is true and the instruction's own 2-bit condition also passes.

While a block is pending, interrupts are held off. A taken branch ends the block at once. Outside a block, instructions are gated only by their own 2-bit condition. Instruction fetch and flag generation are outside this block. The sequencer sits beside the issue stage and produces a per-instruction execute enable.

Top module: `cond_block_seq`

## Requirements
- R1: After reset no block is active: `irq_inhibit_o` is low, and `exec_o` depends only on the issued instruction's own condition.
- R2: The extended code is a truth table over the flags. The result is bit `cond_i[2*C + Z]`. For example, "below or equal" (C OR Z) is `4'b1110`, and "always" is `4'b1111`.
- R3: The per-instruction condition `icond_i` is evaluated on the current flags: 00 always, 01 Z=1, 10 C=1, 11 Z=0. `exec_o` is high only while `issue_i` is high.
- R4: While a block is active, `exec_o` equals `issue_i` AND the latched block result AND the instruction's own condition.
- R5: The block result is latched when the block is set up. Flag changes inside the block do not re-evaluate it.
- R6: Each cycle with `issue_i` high during an active block uses up one slot. Cycles without `issue_i` use up nothing. After `len_i` issued instructions the block ends, and the next instruction is gated by its own condition only.
- R7: The code `4'b0000` ("never") suppresses every instruction in the block.
- R8: `irq_inhibit_o` is high in the setup cycle of a non-empty block and stays high until the block ends.
- R9: A cycle with `branch_i` high cancels the block from the next cycle on. The branching instruction itself is still gated by the block. A setup in the same cycle as a branch is discarded.
- R10: A setup with `len_i` equal to 0 changes nothing: an active block continues unchanged, and when idle `irq_inhibit_o` stays low.
- R11: A non-empty setup while a block is active replaces that block with the new result and length. `issue_i` in a setup cycle does not use up a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Setup instruction issued this cycle |
| cond_i | input | 4 | Extended condition truth table |
| len_i | input | LEN_W | Number of instructions governed |
| c_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| issue_i | input | 1 | An ordinary instruction issues this cycle |
| icond_i | input | 2 | Issued instruction's own condition |
| branch_i | input | 1 | Branch taken this cycle |
| exec_o | output | 1 | Execute enable for the issued instruction |
| irq_inhibit_o | output | 1 | Interrupts held off |

## Verification
A wrong remaining count shows up as a block that ends too early or too late. This appears in the same cycle as a wrongly gated `exec_o`, or as `irq_inhibit_o` staying high or dropping out of step. A wrongly latched result shows up on the first issued instruction of the block, and it persists even when the flags change. The bench compares both outputs against a behavioural model on every cycle, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned XCOND_W = 1 << FLAG_N;

  typedef enum logic [1:0] {
    ICOND_ALWAYS = 2'b00,
    ICOND_Z      = 2'b01,
    ICOND_C      = 2'b10,
    ICOND_NZ     = 2'b11
  } icond_e;

  typedef struct packed {
    logic c;
    logic z;
  } flags_t;
endpackage

// File: rtl/cbs_cond_eval.sv
module cbs_cond_eval
  import cbs_pkg::*;
(
  input  logic [XCOND_W-1:0] xcond_i,
  input  logic [1:0]         icond_i,
  input  flags_t             flags_i,
  output logic               xpass_o,
  output logic               ipass_o
);
  always_comb begin
    xpass_o = xcond_i[{flags_i.c, flags_i.z}];
    unique case (icond_e'(icond_i))
      ICOND_ALWAYS: ipass_o = 1'b1;
      ICOND_Z:      ipass_o = flags_i.z;
      ICOND_C:      ipass_o = flags_i.c;
      default:      ipass_o = ~flags_i.z;
    endcase
  end
endmodule

// File: rtl/cbs_span_counter.sv
module cbs_span_counter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  input  logic             cancel_i,
  output logic             active_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cancel_i)          cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i;
    else if (step_i && active_o) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = |cnt_q;
endmodule

// File: rtl/cond_block_seq.sv
module cond_block_seq
  import cbs_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_i,
  input  logic [3:0]       cond_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             c_i,
  input  logic             z_i,
  input  logic             issue_i,
  input  logic [1:0]       icond_i,
  input  logic             branch_i,
  output logic             exec_o,
  output logic             irq_inhibit_o
);
  flags_t flags;
  logic   xpass, ipass, active, blk_pass_q, load;

  assign flags = '{c: c_i, z: z_i};
  // zero-length setups and setups under a branch are dropped
  assign load  = setup_i && (len_i != '0) && !branch_i;

  cbs_cond_eval u_eval (
    .xcond_i (cond_i),
    .icond_i (icond_i),
    .flags_i (flags),
    .xpass_o (xpass),
    .ipass_o (ipass)
  );

  cbs_span_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .len_i    (len_i),
    .step_i   (issue_i && !setup_i),
    .cancel_i (branch_i),
    .active_o (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   blk_pass_q <= 1'b0;
    else if (load) blk_pass_q <= xpass;
  end

  assign exec_o        = issue_i && ipass && (!active || blk_pass_q);
  assign irq_inhibit_o = active || load;
endmodule

// File: rtl/cond_block_seq_chk.sv
module cond_block_seq_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             setup_i,
  input logic [3:0]       cond_i,
  input logic [LEN_W-1:0] len_i,
  input logic             issue_i,
  input logic             branch_i,
  input logic             exec_o,
  input logic             irq_inhibit_o
);
  // R3
  exec_needs_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> issue_i);
  // R9
  branch_cancels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i |=> (!irq_inhibit_o || (setup_i && len_i != '0)));
  // R10
  zero_len_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && len_i == '0 && !irq_inhibit_o) |=>
      (!irq_inhibit_o || (setup_i && len_i != '0)));
  // R7
  never_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && cond_i == 4'b0000 && len_i != '0 && !branch_i) |=>
      (!exec_o || setup_i));
  // R6
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_inhibit_o && !issue_i && !branch_i) |=> irq_inhibit_o);
  // R8
  setup_inhibits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && len_i != '0 && !branch_i) |-> irq_inhibit_o);
endmodule

bind cond_block_seq cond_block_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .setup_i       (setup_i),
  .cond_i        (cond_i),
  .len_i         (len_i),
  .issue_i       (issue_i),
  .branch_i      (branch_i),
  .exec_o        (exec_o),
  .irq_inhibit_o (irq_inhibit_o)
);

// File: tb/cond_block_seq_test.sv
module cond_block_seq_test;
  localparam int LEN_W = 8;
  localparam time TCK = 8ns;

  logic clk = 0, rst_ni = 0;
  logic setup = 0, c = 0, z = 0, issue = 0, branch = 0;
  logic [3:0] cond = 0;
  logic [LEN_W-1:0] len = 0;
  logic [1:0] icond = 0;
  logic exec_o, irq_o;

  int m_cnt = 0;
  bit m_pass = 0;
  int n_chk = 0, n_bad = 0;

  always #(TCK/2) clk = ~clk;

  cond_block_seq #(.LEN_W(LEN_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .setup_i(setup), .cond_i(cond), .len_i(len),
    .c_i(c), .z_i(z), .issue_i(issue), .icond_i(icond), .branch_i(branch),
    .exec_o(exec_o), .irq_inhibit_o(irq_o));

  function automatic bit ic_ok(logic [1:0] k, logic cc, logic zz);
    case (k)
      2'b00: return 1;
      2'b01: return zz;
      2'b10: return cc;
      default: return !zz;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare at mid-cycle, advance model at the edge
  task automatic cyc(string req, bit s, logic [3:0] cd, int ln, bit cc, bit zz,
                     bit iss, logic [1:0] ic, bit br);
    bit e_exec, e_irq, ld;
    @(negedge clk);
    setup = s; cond = cd; len = ln[LEN_W-1:0]; c = cc; z = zz;
    issue = iss; icond = ic; branch = br;
    ld = s && ln != 0 && !br;
    e_exec = iss && ic_ok(ic, cc, zz) && (m_cnt == 0 || m_pass);
    e_irq = (m_cnt != 0) || ld;
    #1;
    chk(req, exec_o, e_exec, "exec_o");
    chk(req, irq_o, e_irq, "irq_inhibit_o");
    @(posedge clk);
    if (br) m_cnt = 0;
    else if (ld) begin m_cnt = ln; m_pass = cd[{cc, zz}]; end
    else if (iss && m_cnt != 0) m_cnt--;
  endtask

  task automatic ins(string req, bit cc, bit zz, logic [1:0] ic = 2'b00);
    cyc(req, 0, 0, 0, cc, zz, 1, ic, 0);
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 3);
    @(negedge clk); #1;
    chk("R1", irq_o, 1'b0, "irq in reset");
    rst_ni = 1;
    // R1 R3: idle, every own condition against every flag pair
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 4; f++) begin
        cyc("R3", 0, 0, 0, f[1], f[0], 1, k[1:0], 0);
        cyc("R3", 0, 0, 0, f[1], f[0], 0, k[1:0], 0);
      end
    // R2: every code against every flag pair, one-instruction blocks
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 4; f++) begin
        cyc("R2", 1, cd[3:0], 1, f[1], f[0], 0, 0, 0);
        ins("R2", 0, 0);
        ins("R2", 1, 1);
      end
    // R5 R4 R6: below-or-equal true at setup, flags change inside
    cyc("R5", 1, 4'b1110, 3, 0, 1, 0, 0, 0);
    ins("R5", 0, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    ins("R4", 0, 0, 2'b01);
    ins("R4", 0, 1, 2'b11);
    ins("R6", 0, 0);
    // false block then flags true inside
    cyc("R5", 1, 4'b1110, 2, 0, 0, 0, 0, 0);
    ins("R5", 1, 1);
    ins("R5", 1, 0);
    ins("R6", 0, 0);
    // R7 never
    cyc("R7", 1, 4'b0000, 4, 1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) ins("R7", i[0], i[1]);
    ins("R7", 0, 0);
    // R8 long block with gaps
    cyc("R8", 1, 4'b1111, 5, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0);
      ins("R8", 0, 0);
    end
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 cancel mid-block
    cyc("R9", 1, 4'b0000, 6, 0, 0, 0, 0, 0);
    ins("R9", 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 1);
    ins("R9", 0, 0);
    // R9 branch with setup in the same cycle
    cyc("R9", 1, 4'b0000, 3, 0, 0, 0, 0, 1);
    ins("R9", 0, 0);
    // R10 zero length idle and active
    cyc("R10", 1, 4'b0000, 0, 0, 0, 0, 0, 0);
    ins("R10", 0, 0);
    cyc("R10", 1, 4'b1111, 2, 0, 0, 0, 0, 0);
    cyc("R10", 1, 4'b0000, 0, 0, 0, 0, 0, 0);
    ins("R10", 0, 0);
    ins("R10", 0, 0);
    ins("R10", 0, 0);
    // R11 replacement, issue in setup cycle not counted
    cyc("R11", 1, 4'b1111, 4, 0, 0, 0, 0, 0);
    ins("R11", 0, 0);
    cyc("R11", 1, 4'b0000, 2, 0, 0, 1, 0, 0);
    ins("R11", 0, 0);
    ins("R11", 0, 0);
    ins("R11", 0, 0);
    // R6 full-length block
    cyc("R6", 1, 4'b0001, 255, 0, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) ins("R6", 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule